// File: doc/BRIEF.md
# Transceiver Fault Status and Interrupt Register Bank

This block is the control and status register bank of a line transceiver. A host reaches it through a simple register port with a 2-bit address, a write strobe and a read strobe. The block takes condition signals that are already digital: output-driver fault, line-driver fault, supply undervoltage, over-temperature set and clear comparator outputs, regulator undervoltage, wake-up detect and line-driver enable. From these it keeps live fault bits in a mode register and latched interrupt flags in a status register, and it drives an active-low interrupt request.

The mode register also holds the host's control bits: a software reset, a wake-up interrupt enable, a gate for the regulator undervoltage pin and a regulator disable. The software reset holds the whole bank cleared until the host writes it back to zero. In parallel-pin mode, the fault and undervoltage pins mirror the live bits directly. This lets a system without a host port still see the conditions.

Top module: `fault_status_regbank`

## Requirements
- R1: After the synchronous reset `rst`, both registers read 0x00, `irq_n` is 1, and `uv_pin`, `out_flt_pin`, `line_flt_pin` and `reg_off` are 0.
- R2: The mode register sits at address 3. Its bit 7 is the software reset, bit 6 the wake interrupt enable, bit 1 the regulator-undervoltage pin enable and bit 0 the regulator disable. Writes change only bits 7, 6, 1 and 0. Bits 5, 4, 3 and 2 ignore write data.
- R3: Mode bits 5, 4, 3 and 2 are live copies of output-driver fault, line-driver fault, supply undervoltage and over-temperature. Each takes its value one clock after the condition input. Supply undervoltage is seen only while `aux5_ok` is 1.
- R4: The status register sits at address 0. Its flags are wake (bit 0), output-driver fault (bit 1), line-driver fault (bit 2), supply undervoltage (bit 3), over-temperature (bit 4) and regulator undervoltage (bit 5); bits 7 and 6 read 0. A flag latches on the same clock on which its condition becomes active. `irq_n` is 0 while any flag is set.
- R5: A read strobe returns the addressed register on `reg_rdata` in the cycle after the strobe. Addresses 1 and 2 read 0x00. Reading the status register clears every flag, unless a new condition sets that flag in the same cycle.
- R6: Writing 1 to bit 7 of the mode register clears all flags, live bits and control bits on that clock. While bit 7 stays 1, the mode register reads 0x80, the status reads 0x00, `irq_n` stays 1 and no new flag is latched. Conditions still present once bit 7 is written back to 0 are latched again.
- R7: A rising wake-up detect sets the wake flag only while the wake interrupt enable and `drv_en` are both 1. `wake_pin` follows `wake_in` while `drv_en` is 1, whatever the enable is.
- R8: Over-temperature sets when `temp_hi_in` is 1. It stays set until `temp_lo_in` reports the temperature below the clear point.
- R9: A regulator undervoltage latches the regulator flag and asserts `irq_n` whatever the pin enable is. It drives `uv_pin` only while mode bit 1 is 1.
- R10: While `par_mode` is 1, `out_flt_pin`, `line_flt_pin` and `uv_pin` mirror the live output-driver fault, line-driver fault and supply-undervoltage bits. While it is 0, the two fault pins stay 0.
- R11: `reg_off` equals mode bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| par_mode | input | 1 | Parallel-pin mode select |
| out_flt_in | input | 1 | Output-driver fault condition |
| line_flt_in | input | 1 | Line-driver fault condition |
| sup_uv_in | input | 1 | Supply undervoltage condition |
| aux5_ok | input | 1 | Auxiliary supply present |
| temp_hi_in | input | 1 | Temperature above set threshold |
| temp_lo_in | input | 1 | Temperature below clear threshold |
| reg_uv_in | input | 1 | Regulator undervoltage condition |
| wake_in | input | 1 | Wake-up detect |
| drv_en | input | 1 | Line driver enabled |
| irq_n | output | 1 | Interrupt request, active low |
| uv_pin | output | 1 | Undervoltage indicator |
| out_flt_pin | output | 1 | Output-driver fault indicator |
| line_flt_pin | output | 1 | Line-driver fault indicator |
| wake_pin | output | 1 | Wake-up indicator |
| reg_off | output | 1 | Regulator disable control |

## Verification
The latching path is driven with each condition alone, then with all of them at once, and with supply undervoltage both with and without the auxiliary supply. These runs show that every flag and live bit sits in its own position and that gating takes out only the supply bit. Directed runs separate a level from an event: a fault that stays active must not latch again after a clear-on-read. Over-temperature must hold through a window where neither comparator is active. The wake flag must need both the enable and the driver. Software reset is checked for holding the bank clear while conditions are active, and for latching them again once it is released.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int DW = 8;
    localparam int AW = 2;
    localparam logic [AW-1:0] ADDR_STATUS = 2'd0;
    localparam logic [AW-1:0] ADDR_MODE   = 2'd3;

    // mode register layout, MSB first
    typedef struct packed {
        logic swrst;
        logic wake_en;
        logic out_flt;
        logic line_flt;
        logic sup_uv;
        logic otemp;
        logic ruv_pin_en;
        logic reg_off;
    } mode_t;

    typedef struct packed {
        logic swrst;
        logic wake_en;
        logic ruv_pin_en;
        logic reg_off;
    } ctrl_t;

    typedef struct packed {
        logic out_flt;
        logic line_flt;
        logic sup_uv;
        logic otemp;
    } live_t;

    // status register layout, MSB first
    typedef struct packed {
        logic [1:0] rsvd;
        logic ruv;
        logic otemp;
        logic sup_uv;
        logic line_flt;
        logic out_flt;
        logic wake;
    } stat_t;

    // one-cycle onset strobes
    typedef struct packed {
        logic ruv;
        logic otemp;
        logic sup_uv;
        logic line_flt;
        logic out_flt;
        logic wake;
    } evt_t;

    function automatic mode_t pack_mode(ctrl_t c, live_t l);
        mode_t m;
        m.swrst      = c.swrst;
        m.wake_en    = c.wake_en;
        m.out_flt    = l.out_flt;
        m.line_flt   = l.line_flt;
        m.sup_uv     = l.sup_uv;
        m.otemp      = l.otemp;
        m.ruv_pin_en = c.ruv_pin_en;
        m.reg_off    = c.reg_off;
        return m;
    endfunction

    function automatic stat_t evt_to_stat(evt_t e);
        stat_t s;
        s.rsvd     = 2'b00;
        s.ruv      = e.ruv;
        s.otemp    = e.otemp;
        s.sup_uv   = e.sup_uv;
        s.line_flt = e.line_flt;
        s.out_flt  = e.out_flt;
        s.wake     = e.wake;
        return s;
    endfunction
endpackage

// File: rtl/fsr_cond_track.sv
module fsr_cond_track
    import fsr_pkg::*;
(
    input  logic  clk,
    input  logic  srst,
    input  logic  out_flt_in,
    input  logic  line_flt_in,
    input  logic  sup_uv_in,
    input  logic  aux5_ok,
    input  logic  temp_hi_in,
    input  logic  temp_lo_in,
    input  logic  reg_uv_in,
    input  logic  wake_in,
    input  logic  drv_en,
    input  logic  wake_en,
    output live_t live,
    output evt_t  evt,
    output logic  ruv_q
);
    live_t live_nxt;
    logic  wake_q;

    always_comb begin
        live_nxt.out_flt  = out_flt_in;
        live_nxt.line_flt = line_flt_in;
        live_nxt.sup_uv   = sup_uv_in & aux5_ok;
        // set comparator wins; clear comparator only releases a held bit
        live_nxt.otemp    = temp_hi_in | (live.otemp & ~temp_lo_in);
    end

    always_comb begin
        evt.out_flt  = ~srst & live_nxt.out_flt  & ~live.out_flt;
        evt.line_flt = ~srst & live_nxt.line_flt & ~live.line_flt;
        evt.sup_uv   = ~srst & live_nxt.sup_uv   & ~live.sup_uv;
        evt.otemp    = ~srst & live_nxt.otemp    & ~live.otemp;
        evt.ruv      = ~srst & reg_uv_in & ~ruv_q;
        evt.wake     = ~srst & wake_in & ~wake_q & drv_en & wake_en;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            live   <= '0;
            ruv_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            live   <= live_nxt;
            ruv_q  <= reg_uv_in;
            wake_q <= wake_in;
        end
    end

    // R8: without the clear comparator the over-temperature bit holds
    a_r8_otemp_holds: assert property (@(posedge clk) disable iff (srst)
        (live.otemp && !temp_lo_in) |=> live.otemp);

    // R3: supply undervoltage invisible without the auxiliary supply
    a_r3_sup_gated: assert property (@(posedge clk) disable iff (srst)
        !aux5_ok |=> !live.sup_uv);
endmodule

// File: rtl/fsr_irq_flags.sv
module fsr_irq_flags
    import fsr_pkg::*;
(
    input  logic  clk,
    input  logic  srst,
    input  evt_t  evt,
    input  logic  rd_clr,
    output stat_t stat,
    output logic  irq_n
);
    stat_t set_vec;
    stat_t keep_vec;

    always_comb begin
        set_vec  = evt_to_stat(evt);
        keep_vec = rd_clr ? stat_t'('0) : stat;
    end

    always_ff @(posedge clk) begin
        if (srst) stat <= '0;
        else      stat <= keep_vec | set_vec;
    end

    assign irq_n = ~(|stat);

    // R5: a status read with no fresh onset empties the register
    a_r5_read_clears: assert property (@(posedge clk) disable iff (srst)
        (rd_clr && !(|evt)) |=> (stat == '0));
endmodule

// File: rtl/fsr_host_port.sv
module fsr_host_port
    import fsr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    input  live_t         live,
    input  stat_t         stat,
    output ctrl_t         ctrl,
    output logic          srst,
    output logic          rd_clr,
    output logic [DW-1:0] rdata
);
    logic  mode_wr;
    mode_t wr_m;
    mode_t rd_m;
    logic  unused_fault_wdata;

    assign mode_wr = wr && (addr == ADDR_MODE);
    assign wr_m    = mode_t'(wdata);
    assign rd_m    = pack_mode(ctrl, live);
    assign unused_fault_wdata = ^{wr_m.out_flt, wr_m.line_flt, wr_m.sup_uv, wr_m.otemp};

    // bank-wide clear: hard reset, held soft reset, or the write that sets it
    assign srst   = rst | ctrl.swrst | (mode_wr & wr_m.swrst);
    assign rd_clr = rd && (addr == ADDR_STATUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (mode_wr) begin
            ctrl.swrst      <= wr_m.swrst;
            ctrl.wake_en    <= wr_m.wake_en    & ~wr_m.swrst;
            ctrl.ruv_pin_en <= wr_m.ruv_pin_en & ~wr_m.swrst;
            ctrl.reg_off    <= wr_m.reg_off    & ~wr_m.swrst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            case (addr)
                ADDR_STATUS: rdata <= stat;
                ADDR_MODE:   rdata <= rd_m;
                default:     rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/fault_status_regbank.sv
module fault_status_regbank
    import fsr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          par_mode,
    input  logic          out_flt_in,
    input  logic          line_flt_in,
    input  logic          sup_uv_in,
    input  logic          aux5_ok,
    input  logic          temp_hi_in,
    input  logic          temp_lo_in,
    input  logic          reg_uv_in,
    input  logic          wake_in,
    input  logic          drv_en,
    output logic          irq_n,
    output logic          uv_pin,
    output logic          out_flt_pin,
    output logic          line_flt_pin,
    output logic          wake_pin,
    output logic          reg_off
);
    ctrl_t ctrl;
    live_t live;
    evt_t  evt;
    stat_t stat;
    logic  srst;
    logic  rd_clr;
    logic  ruv_q;

    fsr_host_port u_port (
        .clk    (clk),
        .rst    (rst),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .wdata  (reg_wdata),
        .live   (live),
        .stat   (stat),
        .ctrl   (ctrl),
        .srst   (srst),
        .rd_clr (rd_clr),
        .rdata  (reg_rdata)
    );

    fsr_cond_track u_cond (
        .clk         (clk),
        .srst        (srst),
        .out_flt_in  (out_flt_in),
        .line_flt_in (line_flt_in),
        .sup_uv_in   (sup_uv_in),
        .aux5_ok     (aux5_ok),
        .temp_hi_in  (temp_hi_in),
        .temp_lo_in  (temp_lo_in),
        .reg_uv_in   (reg_uv_in),
        .wake_in     (wake_in),
        .drv_en      (drv_en),
        .wake_en     (ctrl.wake_en),
        .live        (live),
        .evt         (evt),
        .ruv_q       (ruv_q)
    );

    fsr_irq_flags u_flags (
        .clk    (clk),
        .srst   (srst),
        .evt    (evt),
        .rd_clr (rd_clr),
        .stat   (stat),
        .irq_n  (irq_n)
    );

    assign out_flt_pin  = par_mode & live.out_flt;
    assign line_flt_pin = par_mode & live.line_flt;
    assign uv_pin       = (par_mode & live.sup_uv) | (ctrl.ruv_pin_en & ruv_q);
    assign wake_pin     = wake_in & drv_en;
    assign reg_off      = ctrl.reg_off;

    // R6: a held soft reset keeps the request line idle and the flags empty
    a_r6_swrst_quiet: assert property (@(posedge clk) disable iff (rst)
        ctrl.swrst |-> (irq_n && (stat == '0)));

    // R4: the flag latches together with the live bit
    a_r4_onset_latches: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.swrst && $rose(live.out_flt)) |-> stat.out_flt);

    // R9: the pin enable never masks the regulator flag
    a_r9_flag_ungated: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.swrst && $rose(ruv_q)) |-> stat.ruv);
endmodule

// File: tb/fault_status_regbank_test.sv
module fault_status_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    localparam int WATCHDOG = 20000;
    // {out, line, sup, aux, thi, ruv} , expected mode , expected status
    localparam logic [21:0] VEC [NVEC] = '{
        {6'b100000, 8'h20, 8'h02},
        {6'b010000, 8'h10, 8'h04},
        {6'b001100, 8'h08, 8'h08},
        {6'b001000, 8'h00, 8'h00},
        {6'b000010, 8'h04, 8'h10},
        {6'b000001, 8'h00, 8'h20},
        {6'b111111, 8'h3C, 8'h3E}
    };

    logic clk = 0;
    logic rst = 1;
    logic [1:0] reg_addr = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic par_mode = 0, out_flt_in = 0, line_flt_in = 0, sup_uv_in = 0, aux5_ok = 0;
    logic temp_hi_in = 0, temp_lo_in = 0, reg_uv_in = 0, wake_in = 0, drv_en = 0;
    logic irq_n, uv_pin, out_flt_pin, line_flt_pin, wake_pin, reg_off;
    int checks = 0, fails = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_status_regbank uut (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr_mode(logic [7:0] d);
        reg_addr = 2'd3; reg_wdata = d; reg_wr = 1;
        step();
        reg_wr = 0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1;
        step();
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic drop_all();
        out_flt_in = 0; line_flt_in = 0; sup_uv_in = 0; aux5_ok = 0;
        temp_hi_in = 0; reg_uv_in = 0; temp_lo_in = 1;
        step();
        temp_lo_in = 0;
        step();
    endtask

    initial begin
        logic [7:0] d;
        repeat (2) step();
        rst = 0;
        step();
        // R1 reset state
        rd_reg(2'd3, d); check("R1 mode", d, 8'h00);
        rd_reg(2'd0, d); check("R1 status", d, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 pins", {4'd0, uv_pin, out_flt_pin, line_flt_pin, reg_off}, 8'h00);

        // R3 R4 table walk
        for (int i = 0; i < NVEC; i++) begin
            {out_flt_in, line_flt_in, sup_uv_in, aux5_ok, temp_hi_in, reg_uv_in} = VEC[i][21:16];
            step();
            check("R4 irq_n", {7'd0, irq_n}, {7'd0, VEC[i][7:0] == 8'h00});
            rd_reg(2'd3, d); check("R3 live bits", d, VEC[i][15:8]);
            rd_reg(2'd0, d); check("R4 flags", d, VEC[i][7:0]);
            drop_all();
        end

        // R2 fault bits ignore writes, R11 regulator disable
        wr_mode(8'h3D);
        rd_reg(2'd3, d); check("R2 write mask", d, 8'h01);
        check("R11 reg_off", {7'd0, reg_off}, 8'h01);
        rd_reg(2'd1, d); check("R5 unused address", d, 8'h00);
        wr_mode(8'h00);

        // R5 clear on read while fault persists
        out_flt_in = 1; step();
        rd_reg(2'd0, d); check("R5 first read", d, 8'h02);
        rd_reg(2'd0, d); check("R5 cleared", d, 8'h00);
        check("R5 irq released", {7'd0, irq_n}, 8'h01);
        rd_reg(2'd3, d); check("R5 live kept", d, 8'h20);

        // R6 soft reset hold and release
        wr_mode(8'hC1);
        check("R6 irq_n held", {7'd0, irq_n}, 8'h01);
        check("R6 reg_off cleared", {7'd0, reg_off}, 8'h00);
        line_flt_in = 1; step();
        check("R6 no new irq", {7'd0, irq_n}, 8'h01);
        rd_reg(2'd0, d); check("R6 status", d, 8'h00);
        rd_reg(2'd3, d); check("R6 mode", d, 8'h80);
        wr_mode(8'h00);
        step();
        check("R6 relatch irq", {7'd0, irq_n}, 8'h00);
        rd_reg(2'd0, d); check("R6 relatch flags", d, 8'h06);
        rd_reg(2'd3, d); check("R6 live after", d, 8'h30);
        drop_all();

        // R7 wake-up
        drv_en = 1; wake_in = 1; step();
        check("R7 wake pin", {7'd0, wake_pin}, 8'h01);
        check("R7 disabled irq", {7'd0, irq_n}, 8'h01);
        wake_in = 0; step();
        wr_mode(8'h40);
        drv_en = 0; wake_in = 1; step();
        check("R7 driver off", {7'd0, irq_n}, 8'h01);
        check("R7 pin needs driver", {7'd0, wake_pin}, 8'h00);
        wake_in = 0; step();
        drv_en = 1; wake_in = 1; step();
        check("R7 wake irq", {7'd0, irq_n}, 8'h00);
        wake_in = 0;
        rd_reg(2'd0, d); check("R7 wake flag", d, 8'h01);
        rd_reg(2'd3, d); check("R7 mode", d, 8'h40);
        wr_mode(8'h00);

        // R8 hysteresis
        temp_hi_in = 1; step();
        temp_hi_in = 0; step(); step();
        rd_reg(2'd3, d); check("R8 held", d, 8'h04);
        temp_lo_in = 1; step();
        temp_lo_in = 0;
        rd_reg(2'd3, d); check("R8 released", d, 8'h00);
        rd_reg(2'd0, d); check("R8 flag", d, 8'h10);

        // R9 regulator undervoltage pin gate
        reg_uv_in = 1; step();
        check("R9 pin gated", {7'd0, uv_pin}, 8'h00);
        check("R9 irq", {7'd0, irq_n}, 8'h00);
        wr_mode(8'h02);
        check("R9 pin enabled", {7'd0, uv_pin}, 8'h01);
        rd_reg(2'd0, d); check("R9 flag", d, 8'h20);
        reg_uv_in = 0; step();
        check("R9 pin drops", {7'd0, uv_pin}, 8'h00);
        wr_mode(8'h00);

        // R10 parallel pins
        par_mode = 1; out_flt_in = 1; step();
        check("R10 out pin", {6'd0, out_flt_pin, line_flt_pin}, 8'h02);
        line_flt_in = 1; sup_uv_in = 1; aux5_ok = 1; step();
        check("R10 all pins", {5'd0, out_flt_pin, line_flt_pin, uv_pin}, 8'h07);
        par_mode = 0; step();
        check("R10 serial mode", {5'd0, out_flt_pin, line_flt_pin, uv_pin}, 8'h00);
        drop_all();
        rd_reg(2'd0, d); check("R10 flags", d, 8'h0E);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule